// File: doc/BRIEF.md
# Bus Grant Time-out Monitor

This block sits next to a parallel-bus arbiter and watches every grant that the arbiter issues. The arbitration itself is done elsewhere and arrives here as a single grant level, `arb_grant`. The block passes that grant on to the bus one clock later as `bus_grant`. While the grant is active, the block waits for the granted master to confirm that it owns the bus by raising bus-busy.

When the time-out is enabled and the acknowledgement does not come within a fixed window of microsecond ticks, the block recovers the bus by itself. It drives bus-busy for one tick period, withdraws the stalled grant, and pulses `rearb` so the arbiter can choose again among the requests that are still waiting. A sticky status bit records that a recovery took place.

Software uses a small byte-wide register. Bit 0 enables the time-out. Bit 1 is the sticky expiry flag, which is cleared by writing a one to it. All other bits read as zero.

Top module: `grant_watchdog`

## Requirements
- R1: After synchronous reset, the enable bit (bit 0) and the status bit (bit 1) are 0, `reg_rdata` is 0, and `bus_grant`, `bbsy_drive` and `rearb` are all 0.
- R2: A write sets the enable bit to `reg_wdata[0]`. `reg_rdata[0]` shows the enable bit, `reg_rdata[1]` shows the status bit, and bits 7..2 always read 0.
- R3: While the enable bit is 0, no expiry occurs however long the grant is held. `bus_grant` follows `arb_grant` with one clock of delay.
- R4: With the enable bit set and `arb_grant` held without bus-busy, expiry takes place at the clock edge that samples the WINDOW_TICKS-th `us_tick` (default 256) after the grant rose. After that edge, `bus_grant` is 0, `bbsy_drive` is 1 and the status bit is 1.
- R5: If `bbsy_in` is seen while the grant is active and not yet withdrawn, the count stops and no expiry occurs for the rest of that grant. This holds even when `bbsy_in` arrives at the same edge as the final tick.
- R6: Whenever `arb_grant` is low, the count is cleared, so every new grant gets a full window.
- R7: The self-driven `bbsy_drive` stays high until the next clock edge that samples `us_tick`, and is released after that edge.
- R8: `rearb` is a single-cycle pulse issued in the same cycle that the grant is withdrawn.
- R9: After an expiry, `bus_grant` stays low until `arb_grant` has gone low.
- R10: Writing 1 to bit 1 clears the status bit. Writing 0 to bit 1 leaves it unchanged.
- R11: Clearing the enable bit during a window discards the ticks already counted. After the bit is set again, a full window is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| arb_grant | input | 1 | Grant level from the external arbiter |
| bbsy_in | input | 1 | Bus-busy as observed on the bus |
| bbsy_drive | output | 1 | Bus-busy driven by this block during recovery |
| bus_grant | output | 1 | Grant passed on to the bus, removed on expiry |
| rearb | output | 1 | One-cycle request to rearbitrate |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data |

## Verification
The bench counts the ticks between the grant rising and `rearb`, and expects exactly the window length. A counter that is off by one would show up as an expiry one tick early or one tick late. It also places the bus-busy acknowledgement on the very edge of the final tick, where a design that let expiry win would wrongly seize the bus. Other cases cover dropping the grant partway through a window and toggling the enable bit partway through a window: a design that kept stale counts would expire early. A grant held high after expiry checks that the grant is not handed back on the next cycle.

// File: rtl/gw_pkg.sv
package gw_pkg;
  localparam int EN_POS = 0;
  localparam int ST_POS = 1;

  typedef struct packed {
    logic set_en;
    logic en_val;
    logic clr_st;
  } reg_cmd_t;
endpackage

// File: rtl/gw_ctrl_reg.sv
module gw_ctrl_reg
  import gw_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  reg_cmd_t         cmd,
  input  logic             expire,
  output logic             enable,
  output logic [REG_W-1:0] rdata
);
  logic status;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= 1'b0;
      status <= 1'b0;
    end else begin
      if (cmd.set_en) enable <= cmd.en_val;
      if (expire) status <= 1'b1;
      else if (cmd.clr_st) status <= 1'b0;
    end
  end

  always_comb begin
    rdata         = '0;
    rdata[EN_POS] = enable;
    rdata[ST_POS] = status;
  end
endmodule

// File: rtl/gw_window_cnt.sv
module gw_window_cnt #(
  parameter int WINDOW_TICKS = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic grant,
  input  logic bbsy,
  input  logic tick,
  input  logic revoked,
  output logic expire
);
  localparam int CNT_W = (WINDOW_TICKS > 1) ? $clog2(WINDOW_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_TICKS - 1);

  logic [CNT_W-1:0] cnt;
  logic             acked;
  logic             live;

  assign live   = grant && !revoked;
  assign expire = live && !bbsy && !acked && enable && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      acked <= 1'b0;
    end else if (!grant) begin
      cnt   <= '0;
      acked <= 1'b0;
    end else if (live) begin
      if (bbsy) begin
        acked <= 1'b1;
        cnt   <= '0;
      end else if (!enable || acked || expire) begin
        cnt <= '0;
      end else if (tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gw_recover.sv
module gw_recover (
  input  logic clk,
  input  logic rst,
  input  logic grant,
  input  logic tick,
  input  logic expire,
  output logic revoked,
  output logic bus_grant,
  output logic bbsy_drive,
  output logic rearb
);
  logic revoked_nxt;

  always_comb begin
    if (!grant) revoked_nxt = 1'b0;
    else        revoked_nxt = revoked || expire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      revoked    <= 1'b0;
      bus_grant  <= 1'b0;
      bbsy_drive <= 1'b0;
      rearb      <= 1'b0;
    end else begin
      revoked   <= revoked_nxt;
      bus_grant <= grant && !revoked_nxt;
      rearb     <= expire;
      if (expire)    bbsy_drive <= 1'b1;
      else if (tick) bbsy_drive <= 1'b0;
    end
  end
endmodule

// File: rtl/grant_watchdog.sv
module grant_watchdog
  import gw_pkg::*;
#(
  parameter int WINDOW_TICKS = 256,
  parameter int REG_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             us_tick,
  input  logic             arb_grant,
  input  logic             bbsy_in,
  output logic             bbsy_drive,
  output logic             bus_grant,
  output logic             rearb,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata
);
  reg_cmd_t cmd;
  logic     enable;
  logic     expire;
  logic     revoked;
  logic     unused_wbits;

  assign unused_wbits = ^reg_wdata;

  always_comb begin
    cmd.set_en = reg_wr;
    cmd.en_val = reg_wdata[EN_POS];
    cmd.clr_st = reg_wr && reg_wdata[ST_POS];
  end

  gw_ctrl_reg #(.REG_W(REG_W)) u_reg (
    .clk(clk), .rst(rst), .cmd(cmd), .expire(expire),
    .enable(enable), .rdata(reg_rdata)
  );

  gw_window_cnt #(.WINDOW_TICKS(WINDOW_TICKS)) u_cnt (
    .clk(clk), .rst(rst), .enable(enable), .grant(arb_grant),
    .bbsy(bbsy_in), .tick(us_tick), .revoked(revoked), .expire(expire)
  );

  gw_recover u_rec (
    .clk(clk), .rst(rst), .grant(arb_grant), .tick(us_tick),
    .expire(expire), .revoked(revoked), .bus_grant(bus_grant),
    .bbsy_drive(bbsy_drive), .rearb(rearb)
  );
endmodule

// File: rtl/gw_checker.sv
module gw_checker #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             us_tick,
  input logic             arb_grant,
  input logic             bbsy_in,
  input logic             bbsy_drive,
  input logic             bus_grant,
  input logic             rearb,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata
);
  AST_REARB_SINGLE: assert property (@(posedge clk) disable iff (rst) rearb |=> !rearb); // R8
  AST_EXPIRY_SEIZES: assert property (@(posedge clk) disable iff (rst) rearb |-> (!bus_grant && bbsy_drive && reg_rdata[1])); // R4
  AST_DRIVE_HOLD: assert property (@(posedge clk) disable iff (rst) (bbsy_drive && !us_tick) |=> bbsy_drive); // R7
  AST_DRIVE_RELEASE: assert property (@(posedge clk) disable iff (rst) (bbsy_drive && us_tick) |=> !bbsy_drive); // R7
  AST_NO_GRANT_IDLE: assert property (@(posedge clk) disable iff (rst) !arb_grant |=> !bus_grant); // R9
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst) (reg_rdata[1] && !(reg_wr && reg_wdata[1])) |=> reg_rdata[1]); // R10
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst) !reg_rdata[0] |=> !rearb); // R3
  AST_ACK_BLOCKS: assert property (@(posedge clk) disable iff (rst) (arb_grant && bbsy_in && bus_grant) |=> !rearb); // R5
  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (reg_rdata[REG_W-1:2] == '0)); // R2
endmodule

bind grant_watchdog gw_checker #(.REG_W(REG_W)) u_gw_chk (
  .clk(clk), .rst(rst), .us_tick(us_tick), .arb_grant(arb_grant),
  .bbsy_in(bbsy_in), .bbsy_drive(bbsy_drive), .bus_grant(bus_grant),
  .rearb(rearb), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
);

// File: tb/test_grant_watchdog.sv
module test_grant_watchdog;
  localparam int WIN = 256;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       us_tick = 1'b0;
  logic       arb_grant = 1'b0;
  logic       bbsy_in = 1'b0;
  logic       bbsy_drive, bus_grant, rearb;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;

  int total = 0;
  int bad = 0;
  int phase = 0;
  int cycles = 0;

  // behavioural reference state
  int m_cnt = 0;
  bit m_ack = 0, m_rev = 0, m_en = 0, m_st = 0;
  bit m_gnt = 0, m_drv = 0, m_rearb = 0;

  always #2 clk = ~clk;

  grant_watchdog i_grant_watchdog (
    .clk(clk), .rst(rst), .us_tick(us_tick), .arb_grant(arb_grant),
    .bbsy_in(bbsy_in), .bbsy_drive(bbsy_drive), .bus_grant(bus_grant),
    .rearb(rearb), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model, evaluated at every edge
  always @(posedge clk) begin
    bit exp_now, nst, nrev;
    cycles++;
    if (rst) begin
      m_cnt = 0; m_ack = 0; m_rev = 0; m_en = 0; m_st = 0;
      m_gnt = 0; m_drv = 0; m_rearb = 0;
    end else begin
      exp_now = 0;
      nst = m_st;
      nrev = m_rev;
      if (!arb_grant) begin
        m_cnt = 0; m_ack = 0; nrev = 0;
      end else if (!m_rev) begin
        if (bbsy_in) begin
          m_ack = 1; m_cnt = 0;
        end else if (!m_en || m_ack) begin
          m_cnt = 0;
        end else if (us_tick) begin
          if (m_cnt == WIN - 1) begin
            exp_now = 1; m_cnt = 0; nrev = 1;
          end else m_cnt++;
        end
      end
      if (exp_now) nst = 1;
      else if (reg_wr && reg_wdata[1]) nst = 0;
      if (reg_wr) m_en = reg_wdata[0];
      m_st = nst;
      m_rev = nrev;
      m_gnt = arb_grant && !nrev;
      m_rearb = exp_now;
      if (exp_now) m_drv = 1;
      else if (us_tick) m_drv = 0;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(bus_grant == m_gnt, "R9 bus_grant", bus_grant, m_gnt);
      check(bbsy_drive == m_drv, "R7 bbsy_drive", bbsy_drive, m_drv);
      check(rearb == m_rearb, "R8 rearb", rearb, m_rearb);
      check(reg_rdata == {6'b0, m_st, m_en}, "R2 reg_rdata", reg_rdata, {6'b0, m_st, m_en});
    end
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic one();
    @(negedge clk);
    #0.5;
    phase++;
    us_tick = (phase % 4 == 0);
    reg_wr = 1'b0;
  endtask

  task automatic adv(input int n);
    for (int i = 0; i < n; i++) one();
  endtask

  task automatic wr(input logic [7:0] d);
    one();
    reg_wr = 1'b1;
    reg_wdata = d;
    one();
  endtask

  // counts ticks applied while the grant is up; returns tick count at which rearb was seen
  task automatic measure(input int ack_tick, input int max_ticks, output int rt);
    int tc = 0;
    rt = -1;
    while (tc < max_ticks) begin
      @(negedge clk);
      if (rearb && rt < 0) rt = tc;
      #0.5;
      phase++;
      us_tick = (phase % 4 == 0);
      reg_wr = 1'b0;
      if (us_tick) begin
        tc++;
        if (tc == ack_tick) bbsy_in = 1'b1;
      end
    end
    adv(3);
    if (rearb && rt < 0) rt = tc;
  endtask

  initial begin
    int rt;
    adv(3);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(reg_rdata == 8'h00, "R1 rdata", reg_rdata, 0);
    check(!bus_grant && !bbsy_drive && !rearb, "R1 outputs", {bus_grant, bbsy_drive, rearb}, 0);

    // R2: only bit 0 writable as enable, high bits read zero
    wr(8'hFD);
    check(reg_rdata == 8'h01, "R2 write FD", reg_rdata, 1);
    wr(8'h00);
    check(reg_rdata == 8'h00, "R2 write 00", reg_rdata, 0);

    // R3: disabled, long grant, no expiry
    arb_grant = 1'b1;
    measure(-1, WIN + 40, rt);
    check(rt == -1, "R3 no expiry when disabled", rt, -1);
    check(bus_grant == 1'b1, "R3 grant passed", bus_grant, 1);
    arb_grant = 1'b0;
    adv(4);
    check(bus_grant == 1'b0, "R3 grant follows", bus_grant, 0);

    // R4: expiry at exactly the window-th tick
    wr(8'h01);
    arb_grant = 1'b1;
    measure(-1, WIN + 2, rt);
    check(rt == WIN, "R4 expiry tick", rt, WIN);
    check(reg_rdata[1] == 1'b1, "R4 status set", reg_rdata[1], 1);
    // R9: grant stays withdrawn while arbiter still asserts it
    adv(20);
    check(bus_grant == 1'b0, "R9 withdrawn", bus_grant, 0);
    check(bbsy_drive == 1'b0, "R7 released", bbsy_drive, 0);
    arb_grant = 1'b0;
    adv(4);

    // R10: writing 0 to bit 1 keeps status, writing 1 clears
    wr(8'h01);
    check(reg_rdata[1] == 1'b1, "R10 keep", reg_rdata[1], 1);
    wr(8'h03);
    check(reg_rdata[1] == 1'b0, "R10 clear", reg_rdata[1], 0);

    // R5: acknowledgement mid-window, then on the final tick edge
    arb_grant = 1'b1;
    measure(100, WIN + 80, rt);
    check(rt == -1, "R5 ack mid", rt, -1);
    arb_grant = 1'b0; bbsy_in = 1'b0;
    adv(4);
    arb_grant = 1'b1;
    measure(WIN, WIN + 40, rt);
    check(rt == -1, "R5 ack on last tick", rt, -1);
    check(bus_grant == 1'b1, "R5 grant kept", bus_grant, 1);
    arb_grant = 1'b0; bbsy_in = 1'b0;
    adv(4);

    // R6: grant dropped partway, new grant gets full window
    arb_grant = 1'b1;
    measure(-1, 200, rt);
    arb_grant = 1'b0;
    adv(4);
    arb_grant = 1'b1;
    measure(-1, WIN + 2, rt);
    check(rt == WIN, "R6 full window after regrant", rt, WIN);
    arb_grant = 1'b0;
    adv(4);

    // R11: disable then re-enable partway through a window
    arb_grant = 1'b1;
    measure(-1, 200, rt);
    wr(8'h00);
    wr(8'h01);
    measure(-1, WIN + 2, rt);
    check(rt == WIN, "R11 full window after re-enable", rt, WIN);
    arb_grant = 1'b0;
    adv(8);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule